// File: doc/BRIEF.md
# Privileged Trap Entry and Return Unit

This block owns the processor's privilege state and performs every controlled change of it. It keeps the one-bit privilege mode, the kernel stack pointer, and the saved program counter, saved stack pointer, saved mode and cause that a handler needs. When a system-call instruction, a breakpoint, a fault, an abort or an external interrupt is reported, the unit enters kernel mode, moves execution to a fixed handler address and moves to the kernel stack. All of that state is captured in the same clock edge, so no cycle ever shows a half-entered trap.

A return-from-trap request, legal only in kernel mode, puts back the saved mode, stack pointer and program counter. Privileged operations attempted from user mode are refused: the operation is not allowed to execute and a privilege-violation trap is taken instead. The fetch stage follows `redirect_o`. In any cycle where it is high, the next fetch address is `next_pc_o` and the stack pointer register of the datapath is loaded from `next_sp_o`. Software saves the general registers, and instruction decode stays outside the unit.

Top module: `trap_ctl_unit`

## Requirements
- R1: `mode_o` carries the privilege mode, with 0 meaning user (untrusted) and 1 meaning kernel (trusted).
- R2: While and just after synchronous reset, `mode_o` is 1, `redirect_o` is 1, `next_pc_o` is `BOOT_ADDR`, `next_sp_o` is `KSTACK_TOP` and `cause_o` is 0.
- R3: A trap taken on an edge makes `mode_o` 1 and `redirect_o` 1 after that edge. In the same edge it captures the previous mode, the stack pointer `cur_sp_i` and a resume PC, which a later return brings back.
- R4: A trap from user mode sets `next_sp_o` to the kernel stack pointer register. A trap from kernel mode keeps the current stack and sets `next_sp_o` to `cur_sp_i`.
- R5: Cause 0 (system call) sends `next_pc_o` to `SYSCALL_VEC`. Every other cause sends it to `TRAP_VEC`.
- R6: Causes are 4 bits: 0 system call, 1 breakpoint, 2 privilege violation, 3 divide by zero, 4 page fault, 5 parity abort, and 8+i for interrupt line i. Priority runs 5 > 4 > 3 > 2 > 1 > 0 > interrupts, and among interrupts the lowest index wins. `cause_o` shows the cause of the last trap.
- R7: The resume PC is `cur_pc_i + INSN_BYTES` for causes 0 and 1. For every other cause, including interrupts, it is `cur_pc_i`.
- R8: In user mode `priv_ok_o` is 0, and `priv_op_i` or `ret_i` raises cause 2. In kernel mode `priv_ok_o` equals `priv_op_i` and no trap is raised for it.
- R9: A return in kernel mode gives, one edge later, `redirect_o` 1, `mode_o` equal to the saved mode, `next_pc_o` equal to the saved PC and `next_sp_o` equal to the saved SP. The cause is left unchanged.
- R10: A return whose saved mode is user copies `cur_sp_i` into the kernel stack pointer register. The next trap from user mode then lands on that value.
- R11: In kernel mode, a return in the same cycle as any trap source is ignored, and the trap proceeds alone.
- R12: In a cycle with no trap source and no return, `redirect_o` is 0 after the edge and the mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc_i | input | XLEN | Address of the instruction at the trap point |
| cur_sp_i | input | XLEN | Live stack pointer of the datapath |
| syscall_i | input | 1 | System-call instruction seen |
| brk_i | input | 1 | Breakpoint instruction seen |
| priv_op_i | input | 1 | Privileged operation requested |
| div0_i | input | 1 | Divide-by-zero fault |
| pgfault_i | input | 1 | Page fault |
| parity_i | input | 1 | Parity abort |
| irq_i | input | NIRQ | External interrupt lines |
| ret_i | input | 1 | Return-from-trap request |
| mode_o | output | 1 | Privilege mode |
| redirect_o | output | 1 | Load PC and SP from the next-state outputs |
| next_pc_o | output | XLEN | Fetch address when redirecting |
| next_sp_o | output | XLEN | Stack pointer when redirecting |
| cause_o | output | 4 | Cause of the last trap |
| priv_ok_o | output | 1 | Privileged operation may execute |

## Verification
Every combination of the six synchronous trap sources is applied, once in user mode and once in kernel mode. This separates the priority order, the two handler addresses, the stack choice on entry and the resume-PC rule for retried versus skipped instructions. Each of these traps is followed by a return, which shows whether the saved mode, PC and SP were captured in the same edge. All 255 non-zero interrupt patterns are then applied in kernel mode, which distinguishes lowest-index selection from any other encoding. Directed sequences cover the following cases:
- a return from user mode;
- a return that coincides with a trap;
- a privileged operation in kernel mode;
- reuse of the kernel stack pointer left behind by an earlier return.

// File: rtl/trap_pkg.sv
// Shared cause encoding and the record passed from the selector to the
// state registers. Assumes at most eight interrupt lines (causes 8..15).
package trap_pkg;

    localparam int CAUSE_W = 4;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t C_SYSCALL  = 4'd0;
    localparam cause_t C_BREAK    = 4'd1;
    localparam cause_t C_PRIV     = 4'd2;
    localparam cause_t C_DIV0     = 4'd3;
    localparam cause_t C_PGFAULT  = 4'd4;
    localparam cause_t C_PARITY   = 4'd5;
    localparam cause_t C_IRQ_BASE = 4'd8;

    typedef struct packed {
        logic   take;    // a trap is entered on this edge
        cause_t cause;   // winning cause
    } trap_sel_t;

    // True for causes that resume after the trapping instruction.
    function automatic logic resumes_next(input cause_t c);
        return (c == C_SYSCALL) || (c == C_BREAK);
    endfunction

endpackage

// File: rtl/trap_select.sv
// Fixed-priority selection of the trap to take this cycle. Also gates
// privileged operations by the current mode. Purely combinational; the
// clock and reset are used only by the assertions.
// Assumes NIRQ <= 8 so that every interrupt cause fits in four bits.
module trap_select
    import trap_pkg::*;
#(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_i,
    input  logic            syscall_i,
    input  logic            brk_i,
    input  logic            priv_op_i,
    input  logic            ret_i,
    input  logic            div0_i,
    input  logic            pgfault_i,
    input  logic            parity_i,
    input  logic [NIRQ-1:0] irq_i,
    output trap_sel_t       sel_o,
    output logic            priv_ok_o
);

    logic violation;

    // A privileged request or a return from user mode is a violation.
    assign violation = !mode_i && (priv_op_i || ret_i);

    // Privileged operations run only in kernel mode.
    assign priv_ok_o = mode_i && priv_op_i;

    // Priority chain: lowest priority written first, later writes win.
    always_comb begin
        sel_o.take  = 1'b0;
        sel_o.cause = C_SYSCALL;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (irq_i[i]) begin
                sel_o.take  = 1'b1;
                sel_o.cause = cause_t'(C_IRQ_BASE + cause_t'(i));
            end
        end
        if (syscall_i) begin sel_o.take = 1'b1; sel_o.cause = C_SYSCALL; end
        if (brk_i)     begin sel_o.take = 1'b1; sel_o.cause = C_BREAK;   end
        if (violation) begin sel_o.take = 1'b1; sel_o.cause = C_PRIV;    end
        if (div0_i)    begin sel_o.take = 1'b1; sel_o.cause = C_DIV0;    end
        if (pgfault_i) begin sel_o.take = 1'b1; sel_o.cause = C_PGFAULT; end
        if (parity_i)  begin sel_o.take = 1'b1; sel_o.cause = C_PARITY;  end
    end

    // R8: user mode never lets a privileged operation through.
    p_user_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> !priv_ok_o);

    // R8: a privileged request in user mode always produces a trap.
    p_user_traps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && priv_op_i) |-> sel_o.take);

    // R6: the parity abort outranks every other source.
    p_parity_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        parity_i |-> (sel_o.cause == C_PARITY));

endmodule

// File: rtl/trap_vector.sv
// Computes the handler entry address and the resume PC for the selected
// cause. Purely combinational.
module trap_vector
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              INSN_BYTES  = 4,
    parameter logic [XLEN-1:0] SYSCALL_VEC = 32'h8000_0080,
    parameter logic [XLEN-1:0] TRAP_VEC    = 32'h8000_0100
) (
    input  trap_sel_t       sel_i,
    input  logic [XLEN-1:0] cur_pc_i,
    output logic [XLEN-1:0] handler_pc_o,
    output logic [XLEN-1:0] resume_pc_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // System calls enter their own handler; all else shares one.
    assign handler_pc_o = (sel_i.cause == C_SYSCALL) ? SYSCALL_VEC : TRAP_VEC;

    // Calls and breakpoints resume after the instruction; others retry it.
    assign resume_pc_o = resumes_next(sel_i.cause) ? (cur_pc_i + STEP) : cur_pc_i;

endmodule

// File: rtl/trap_state.sv
// Privilege-state registers: mode, kernel stack pointer, saved context and
// next-PC/SP outputs. A trap and a return each update everything in one
// edge. Assumes the selector has already resolved priorities.
module trap_state
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] BOOT_ADDR   = 32'h0000_1000,
    parameter logic [XLEN-1:0] KSTACK_TOP  = 32'hFFFF_F000,
    parameter logic [XLEN-1:0] SYSCALL_VEC = 32'h8000_0080
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trap_sel_t       sel_i,
    input  logic [XLEN-1:0] handler_pc_i,
    input  logic [XLEN-1:0] resume_pc_i,
    input  logic            ret_i,
    input  logic [XLEN-1:0] cur_sp_i,
    output logic            mode_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic [XLEN-1:0] next_sp_o,
    output cause_t          cause_o
);

    logic            mode_q;
    logic            redirect_q;
    logic [XLEN-1:0] next_pc_q;
    logic [XLEN-1:0] next_sp_q;
    logic [XLEN-1:0] ksp_q;
    logic [XLEN-1:0] spc_q;
    logic [XLEN-1:0] ssp_q;
    logic            smode_q;
    cause_t          scause_q;
    logic            do_ret;

    // A return counts only in kernel mode and only when no trap competes.
    assign do_ret = ret_i && mode_q && !sel_i.take;

    // Single-edge update of the whole privilege context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= 1'b1;
            redirect_q <= 1'b1;
            next_pc_q  <= BOOT_ADDR;
            next_sp_q  <= KSTACK_TOP;
            ksp_q      <= KSTACK_TOP;
            spc_q      <= '0;
            ssp_q      <= '0;
            smode_q    <= 1'b0;
            scause_q   <= C_SYSCALL;
        end else if (sel_i.take) begin
            mode_q     <= 1'b1;
            redirect_q <= 1'b1;
            next_pc_q  <= handler_pc_i;
            next_sp_q  <= mode_q ? cur_sp_i : ksp_q;
            spc_q      <= resume_pc_i;
            ssp_q      <= cur_sp_i;
            smode_q    <= mode_q;
            scause_q   <= sel_i.cause;
        end else if (do_ret) begin
            mode_q     <= smode_q;
            redirect_q <= 1'b1;
            next_pc_q  <= spc_q;
            next_sp_q  <= ssp_q;
            if (!smode_q) begin
                ksp_q <= cur_sp_i;
            end
        end else begin
            redirect_q <= 1'b0;
        end
    end

    assign mode_o     = mode_q;
    assign redirect_o = redirect_q;
    assign next_pc_o  = next_pc_q;
    assign next_sp_o  = next_sp_q;
    assign cause_o    = scause_q;

    // R3: any trap lands in kernel mode with a redirect.
    p_enter_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i.take |=> (mode_q && redirect_q));

    // R4: entry from user mode swaps to the kernel stack.
    p_user_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i.take && !mode_q) |=> (next_sp_q == $past(ksp_q)));

    // R4: entry from kernel mode keeps the live stack.
    p_kern_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i.take && mode_q) |=> (next_sp_q == $past(cur_sp_i)));

    // R5: system calls reach their dedicated handler.
    p_syscall_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i.take && sel_i.cause == C_SYSCALL) |=> (next_pc_q == SYSCALL_VEC));

    // R9: a kernel return restores the saved mode and PC.
    p_ret_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        do_ret |=> (mode_q == $past(smode_q) && next_pc_q == $past(spc_q)));

    // R11: a return alongside a trap leaves kernel mode in place.
    p_ret_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i.take && ret_i) |=> mode_q);

    // R12: a quiet cycle drops the redirect and holds the mode.
    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i.take && !ret_i) |=> (!redirect_q && mode_q == $past(mode_q)));

endmodule

// File: rtl/trap_ctl_unit.sv
// Top of the trap entry and return unit: the selector resolves the event,
// the vector stage forms addresses, and the state stage commits them.
// Assumes trap sources are valid for the cycle they are asserted.
module trap_ctl_unit
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              NIRQ        = 8,
    parameter int              INSN_BYTES  = 4,
    parameter logic [XLEN-1:0] BOOT_ADDR   = 32'h0000_1000,
    parameter logic [XLEN-1:0] SYSCALL_VEC = 32'h8000_0080,
    parameter logic [XLEN-1:0] TRAP_VEC    = 32'h8000_0100,
    parameter logic [XLEN-1:0] KSTACK_TOP  = 32'hFFFF_F000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [XLEN-1:0] cur_sp_i,
    input  logic            syscall_i,
    input  logic            brk_i,
    input  logic            priv_op_i,
    input  logic            div0_i,
    input  logic            pgfault_i,
    input  logic            parity_i,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            ret_i,
    output logic            mode_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic [XLEN-1:0] next_sp_o,
    output logic [3:0]      cause_o,
    output logic            priv_ok_o
);

    trap_sel_t       sel;
    logic [XLEN-1:0] handler_pc;
    logic [XLEN-1:0] resume_pc;
    logic            mode;

    trap_select #(.NIRQ(NIRQ)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .syscall_i (syscall_i),
        .brk_i     (brk_i),
        .priv_op_i (priv_op_i),
        .ret_i     (ret_i),
        .div0_i    (div0_i),
        .pgfault_i (pgfault_i),
        .parity_i  (parity_i),
        .irq_i     (irq_i),
        .sel_o     (sel),
        .priv_ok_o (priv_ok_o)
    );

    trap_vector #(
        .XLEN        (XLEN),
        .INSN_BYTES  (INSN_BYTES),
        .SYSCALL_VEC (SYSCALL_VEC),
        .TRAP_VEC    (TRAP_VEC)
    ) u_vector (
        .sel_i        (sel),
        .cur_pc_i     (cur_pc_i),
        .handler_pc_o (handler_pc),
        .resume_pc_o  (resume_pc)
    );

    trap_state #(
        .XLEN        (XLEN),
        .BOOT_ADDR   (BOOT_ADDR),
        .KSTACK_TOP  (KSTACK_TOP),
        .SYSCALL_VEC (SYSCALL_VEC)
    ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sel),
        .handler_pc_i (handler_pc),
        .resume_pc_i  (resume_pc),
        .ret_i        (ret_i),
        .cur_sp_i     (cur_sp_i),
        .mode_o       (mode),
        .redirect_o   (redirect_o),
        .next_pc_o    (next_pc_o),
        .next_sp_o    (next_sp_o),
        .cause_o      (cause_o)
    );

    assign mode_o = mode;

    // R1: the mode output is always a defined single bit.
    p_mode_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(mode_o));

endmodule

// File: tb/trap_ctl_unit_bench.sv
// Self-checking bench: a small reference model of the privilege state,
// driven by sweeps over trap sources and interrupt patterns.
module trap_ctl_unit_bench;

    localparam logic [31:0] BOOT = 32'h0000_1000;
    localparam logic [31:0] SV   = 32'h8000_0080;
    localparam logic [31:0] TV   = 32'h8000_0100;
    localparam logic [31:0] KST  = 32'hFFFF_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, cur_sp = '0;
    logic        syscall = 0, brk = 0, priv_op = 0, div0 = 0, pgfault = 0, parity = 0;
    logic [7:0]  irq = '0;
    logic        ret = 0;
    logic        mode, redirect, priv_ok;
    logic [31:0] next_pc, next_sp;
    logic [3:0]  cause;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic        m_mode, m_smode;
    logic [31:0] m_ksp, m_spc, m_ssp;
    logic [3:0]  m_cause;

    always #4 clk = ~clk;

    trap_ctl_unit u_trap_ctl_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc_i(cur_pc), .cur_sp_i(cur_sp),
        .syscall_i(syscall), .brk_i(brk), .priv_op_i(priv_op), .div0_i(div0),
        .pgfault_i(pgfault), .parity_i(parity), .irq_i(irq), .ret_i(ret),
        .mode_o(mode), .redirect_o(redirect), .next_pc_o(next_pc),
        .next_sp_o(next_sp), .cause_o(cause), .priv_ok_o(priv_ok)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        syscall = 0; brk = 0; priv_op = 0; div0 = 0; pgfault = 0; parity = 0;
        irq = '0; ret = 0;
    endtask

    // R2: reset state, checked just after release.
    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        rst_n = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_mode = 1; m_smode = 0; m_ksp = KST; m_spc = '0; m_ssp = '0; m_cause = '0;
        #1;
        check("R2", "redirect", {31'b0, redirect}, 32'd1);
        check("R2", "next_pc", next_pc, BOOT);
        check("R2", "next_sp", next_sp, KST);
        check("R2", "cause", {28'b0, cause}, 32'd0);
        check("R1", "mode", {31'b0, mode}, 32'd1);
    endtask

    // One cycle of stimulus with the model's expectation.
    // sb: [0] syscall [1] brk [2] priv_op [3] div0 [4] pgfault [5] parity
    task automatic apply(input logic [5:0] sb, input logic [7:0] iv, input logic r,
                         input logic [31:0] pc, input logic [31:0] sp, input string tag);
        logic        viol, take, e_red;
        logic [3:0]  c;
        logic [31:0] e_pc, e_sp;
        @(negedge clk);
        syscall = sb[0]; brk = sb[1]; priv_op = sb[2]; div0 = sb[3];
        pgfault = sb[4]; parity = sb[5]; irq = iv; ret = r;
        cur_pc = pc; cur_sp = sp;
        #1;
        check("R8", "priv_ok", {31'b0, priv_ok}, {31'b0, m_mode & sb[2]});
        viol = !m_mode && (sb[2] || r);
        take = 1; c = 0;
        if (sb[5]) c = 5;
        else if (sb[4]) c = 4;
        else if (sb[3]) c = 3;
        else if (viol) c = 2;
        else if (sb[1]) c = 1;
        else if (sb[0]) c = 0;
        else if (iv != 0) begin
            for (int i = 7; i >= 0; i--) if (iv[i]) c = 4'(8 + i);
        end else take = 0;
        e_pc = '0; e_sp = '0;
        if (take) begin
            e_red = 1;
            e_pc = (c == 0) ? SV : TV;
            e_sp = m_mode ? sp : m_ksp;
            m_spc = (c <= 1) ? pc + 32'd4 : pc;
            m_ssp = sp; m_smode = m_mode; m_cause = c; m_mode = 1;
        end else if (r) begin
            e_red = 1;
            e_pc = m_spc; e_sp = m_ssp;
            if (!m_smode) m_ksp = sp;
            m_mode = m_smode;
        end else begin
            e_red = 0;
        end
        @(posedge clk);
        #1;
        check(tag, "redirect", {31'b0, redirect}, {31'b0, e_red});
        check(tag, "mode", {31'b0, mode}, {31'b0, m_mode});
        check(tag, "cause", {28'b0, cause}, {28'b0, m_cause});
        if (e_red) begin
            check(tag, "next_pc", next_pc, e_pc);
            check(tag, "next_sp", next_sp, e_sp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        apply(6'b0, 8'h0, 0, 32'h100, 32'h200, "R12");
        // R9 / R1: return from reset state drops to user mode.
        apply(6'b0, 8'h0, 1, 32'h100, 32'hFFFF_E000, "R9");
        check("R1", "user mode", {31'b0, mode}, 32'd0);
        // R10: the kernel SP left by that return is used by the next entry.
        apply(6'b000001, 8'h0, 0, 32'h400, 32'h7000, "R10");
        check("R10", "kernel sp", next_sp, 32'hFFFF_E000);
        apply(6'b0, 8'h0, 1, 32'h0, 32'hFFFF_D000, "R9");
        check("R7", "syscall resume", next_pc, 32'h404);
        check("R3", "saved sp", next_sp, 32'h7000);

        // R7: a divide fault retries, a breakpoint skips.
        apply(6'b001000, 8'h0, 0, 32'h900, 32'h7100, "R7");
        apply(6'b0, 8'h0, 1, 32'h0, 32'hFFFF_D000, "R7");
        check("R7", "fault resume", next_pc, 32'h900);
        apply(6'b000010, 8'h0, 0, 32'hA00, 32'h7200, "R7");
        apply(6'b0, 8'h0, 1, 32'h0, 32'hFFFF_D000, "R7");
        check("R7", "brk resume", next_pc, 32'hA04);

        // R8: a return from user mode is a privilege violation.
        apply(6'b0, 8'h0, 1, 32'hB00, 32'h7300, "R8");
        check("R8", "user ret cause", {28'b0, cause}, 32'd2);

        // R8: a privileged operation in kernel mode runs, no trap.
        apply(6'b000100, 8'h0, 0, 32'hC00, 32'h5000, "R8");

        // R11: a return beside a trap in kernel mode is dropped.
        do_reset();
        apply(6'b000001, 8'h0, 1, 32'hD00, 32'h5100, "R11");
        check("R11", "still kernel", {31'b0, mode}, 32'd1);

        // R6 / R5 / R4 / R3: every synchronous combination in both modes.
        for (int m = 0; m < 2; m++) begin
            for (int k = 1; k < 64; k++) begin
                do_reset();
                if (m == 0) apply(6'b0, 8'h0, 1, 32'h0, 32'hFFFF_C000, "R9");
                apply(6'(k), 8'h0, 0, 32'h2000 + 32'(k) * 16, 32'h6000 + 32'(k) * 32, "R6");
                apply(6'b0, 8'h0, 1, 32'h0, 32'hFFFF_B000, "R3");
            end
        end

        // R6: every interrupt pattern, lowest line wins.
        do_reset();
        for (int v = 1; v < 256; v++) begin
            apply(6'b0, 8'(v), 0, 32'h3000 + 32'(v), 32'h4000 + 32'(v), "R6");
        end
        // R4: interrupt taken from user mode switches stacks.
        do_reset();
        apply(6'b0, 8'h0, 1, 32'h0, 32'hFFFF_A000, "R9");
        apply(6'b0, 8'h30, 0, 32'h3500, 32'h4500, "R4");
        apply(6'b0, 8'h0, 0, 32'h0, 32'h0, "R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule